// File: doc/BRIEF.md
# XOR-Swizzled Tile Buffer

This block stores one 8x8 tile of 32-bit words. Clients address it only with logical (row, column) coordinates. A write delivers a whole column of eight words in one cycle, and a read returns a whole row of eight words one cycle after it is requested. Inside the block, each element's column-major logical offset (row + 8*column) passes through an XOR remap before it reaches storage. The remap takes a group of high offset bits, shifts it down, and folds it into a group of low bits. This staggers the physical placement so that both a column write and a row read touch eight different banks, where a bank is the physical offset modulo 32.

The remap is set at elaboration time by three parameters: the XOR width B, the count M of untouched low bits, and the shift S. B=0 selects a pure pass-through variant. A raw-dump mode lets the read port skip the remap and return storage in physical order. This makes the scrambled placement visible when a tile is being debugged.

Top module: `swz_tile_buf`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is all zero, and every stored word reads back as zero.
- R2: When `wr_en` is high, lane i of `wr_data` (bits 32*i+31 down to 32*i) is stored at logical row i, column `wr_col`. That position has logical offset i + 8*`wr_col`.
- R3: A logical offset L is stored at physical offset L ^ ((L >> S) & mask). Here mask selects B bits starting at bit M, so the low M bits of L are never changed. The defaults are B=3, M=2, S=3.
- R4: A logical read (`rd_raw`=0) of row r returns, in lane j of `rd_data`, the last word written to row r, column j, whatever the remap.
- R5: A read request taken at a clock edge shows up on `rd_data` with `rd_valid`=1 right after that edge. With no request, `rd_valid` is 0 after the edge and `rd_data` keeps its previous value.
- R6: If a read and a write at the same edge touch the same element, the read returns the data that was there before the write.
- R7: A raw read (`rd_raw`=1) with index k returns, in lane j, the word at physical offset 8*k + j, with no remap.
- R8: With the defaults, logical offset 32 (row 0, column 4) sits at physical offset 36. The banks (physical offset mod 32) of row 0, columns 0..7, are 0,8,16,24,4,12,20,28. The banks of column 4, rows 0..7, are 4,5,6,7,0,1,2,3.
- R9: With the defaults, each of the 8 rows and each of the 8 columns occupies 8 distinct banks.
- R10: With B=0 the remap is the identity, so a raw read of index k returns logical column k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one column this cycle |
| wr_col | input | 3 | Column being written |
| wr_data | input | 256 | Eight words, lane i goes to row i |
| rd_en | input | 1 | Read request |
| rd_raw | input | 1 | 1: physical dump order, 0: logical row |
| rd_row | input | 3 | Logical row, or physical group index when raw |
| rd_data | output | 256 | Eight words, lane j is column j (or physical offset 8*k+j) |
| rd_valid | output | 1 | `rd_data` was loaded by the request of the previous cycle |

## Verification
The tile is filled with words that encode their own logical offset, under two different tag values. Logical row reads then show whether data lands at the right coordinates no matter how it is placed. Raw dumps of all eight physical groups reveal where each logical offset ended up. The bench checks those positions against the XOR formula, the quoted offset 32 to 36 case, the listed row-0 and column-4 bank sequences, and the distinct-bank property of every row and column. A pass-through instance with B=0 is dumped the same way to tell the identity variant apart from the swizzled one. A read and write to the same element at one edge separates old-data from new-data behaviour, and an idle cycle after a read checks the valid and hold behaviour.

// File: rtl/swz_pkg.sv
package swz_pkg;

   // Reference remap used by checks: off ^ ((off >> s) & (((1<<b)-1) << m))
   function automatic int unsigned swz_apply(input int unsigned off,
                                             input int unsigned b,
                                             input int unsigned m,
                                             input int unsigned s);
      int unsigned fold_mask;
      fold_mask = ((32'd1 << b) - 32'd1) << m;
      return off ^ ((off >> s) & fold_mask);
   endfunction

endpackage

// File: rtl/swz_map.sv
module swz_map #(
   parameter int OFF_W  = 6,
   parameter int SWZ_B  = 3,
   parameter int SWZ_M  = 2,
   parameter int SWZ_S  = 3
) (
   input  logic [OFF_W-1:0] lin_off,
   output logic [OFF_W-1:0] phy_off
);

   generate
      if (SWZ_B == 0) begin : g_pass
         assign phy_off = lin_off;
      end else begin : g_xor
         localparam logic [OFF_W-1:0] FOLD_MASK =
            OFF_W'(((1 << SWZ_B) - 1) << SWZ_M);
         logic [OFF_W-1:0] shifted;
         assign shifted = lin_off >> SWZ_S;
         assign phy_off = lin_off ^ (shifted & FOLD_MASK);

         // R3: the low M bits pass through unchanged
         if (SWZ_M > 0) begin : g_low_chk
            always_comb begin
               a_r3_low_bits_kept: assert (phy_off[SWZ_M-1:0] == lin_off[SWZ_M-1:0])
                  else $error("swizzle altered a protected low bit");
            end
         end
      end
   endgenerate

endmodule

// File: rtl/swz_store.sv
module swz_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int LANES  = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [LANES-1:0][AW-1:0]      wr_addr,
   input  logic [LANES-1:0][DATA_W-1:0]  wr_data,
   input  logic                          rd_en,
   input  logic [LANES-1:0][AW-1:0]      rd_addr,
   output logic [LANES-1:0][DATA_W-1:0]  rd_data,
   output logic                          rd_valid
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  hit;

   // Which entries any write lane targets this cycle
   always_comb begin
      hit = '0;
      for (int i = 0; i < LANES; i++) begin
         hit[wr_addr[i]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < LANES; i++) mem[wr_addr[i]] <= wr_data[i];
      end
   end

   // Registered read: sees contents from before this edge's write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            for (int j = 0; j < LANES; j++) rd_data[j] <= mem[rd_addr[j]];
         end
      end
   end

   // R2: the lanes of one write never share a storage entry
   a_r2_lanes_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($countones(hit) == LANES))
      else $error("write lanes collide on one entry");

   // R5: valid follows the request by exactly one cycle
   a_r5_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid)
      else $error("read request lost its valid");

   // R5: data is held when no request is taken
   a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> ($stable(rd_data) && !rd_valid))
      else $error("read data changed without a request");

endmodule

// File: rtl/swz_tile_buf.sv
module swz_tile_buf #(
   parameter int DATA_W = 32,
   parameter int TILE   = 8,
   parameter int SWZ_B  = 3,
   parameter int SWZ_M  = 2,
   parameter int SWZ_S  = 3,
   localparam int IDX_W = $clog2(TILE),
   localparam int OFF_W = 2 * IDX_W,
   localparam int DEPTH = TILE * TILE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_col,
   input  logic [TILE*DATA_W-1:0]   wr_data,
   input  logic                     rd_en,
   input  logic                     rd_raw,
   input  logic [IDX_W-1:0]         rd_row,
   output logic [TILE*DATA_W-1:0]   rd_data,
   output logic                     rd_valid
);

   // Elaboration-time parameter checks
   generate
      if ((1 << IDX_W) != TILE) begin : g_bad_tile
         $error("TILE must be a power of two");
      end
      if (SWZ_M + SWZ_B > OFF_W) begin : g_bad_target
         $error("target field [M, M+B) exceeds the offset width");
      end
      if (SWZ_B > 0 && SWZ_S < SWZ_B) begin : g_bad_shift
         $error("source and target fields overlap (S < B)");
      end
   endgenerate

   logic [TILE-1:0][OFF_W-1:0]  wr_lin, wr_phy;
   logic [TILE-1:0][OFF_W-1:0]  rd_lin, rd_phy, rd_sel;
   logic [TILE-1:0][DATA_W-1:0] wr_lane, rd_lane;

   genvar g;
   generate
      for (g = 0; g < TILE; g++) begin : g_lane
         // Write lane g is row g of column wr_col
         assign wr_lin[g]  = {wr_col, IDX_W'(g)};
         // Read lane g is column g of row rd_row
         assign rd_lin[g]  = {IDX_W'(g), rd_row};
         assign wr_lane[g] = wr_data[g*DATA_W +: DATA_W];
         assign rd_data[g*DATA_W +: DATA_W] = rd_lane[g];

         swz_map #(.OFF_W(OFF_W), .SWZ_B(SWZ_B), .SWZ_M(SWZ_M), .SWZ_S(SWZ_S))
            i_wmap (.lin_off(wr_lin[g]), .phy_off(wr_phy[g]));
         swz_map #(.OFF_W(OFF_W), .SWZ_B(SWZ_B), .SWZ_M(SWZ_M), .SWZ_S(SWZ_S))
            i_rmap (.lin_off(rd_lin[g]), .phy_off(rd_phy[g]));

         // Raw dump: physical offset TILE*rd_row + g, no remap
         assign rd_sel[g] = rd_raw ? {rd_row, IDX_W'(g)} : rd_phy[g];

         // R3: the remap is its own inverse
         always_comb begin
            a_r3_self_inverse: assert (swz_pkg::swz_apply(32'(wr_phy[g]), SWZ_B, SWZ_M, SWZ_S)
                                       == 32'(wr_lin[g]))
               else $error("remap applied twice did not return the offset");
         end
      end
   endgenerate

   swz_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(TILE)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_phy),
      .wr_data  (wr_lane),
      .rd_en    (rd_en),
      .rd_addr  (rd_sel),
      .rd_data  (rd_lane),
      .rd_valid (rd_valid)
   );

   // R1: nothing is valid on the first cycle after reset
   a_r1_idle_after_reset: assert property (@(posedge clk)
      !rst_n |=> !rd_valid)
      else $error("valid asserted straight out of reset");

endmodule

// File: tb/test_swz_tile_buf.sv
`timescale 1ns/1ps
module test_swz_tile_buf;

   localparam int DW = 32;
   localparam int T  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_col = '0;
   logic [T*DW-1:0] wr_data = '0;
   logic rd_en = 1'b0;
   logic rd_raw = 1'b0;
   logic [2:0] rd_row = '0;
   logic [T*DW-1:0] rd_data, rd_data_id;
   logic rd_valid, rd_valid_id;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] dump [64];
   int where_p [64];

   always #2.5 clk = ~clk;

   swz_tile_buf i_swz_tile_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
      .rd_en(rd_en), .rd_raw(rd_raw), .rd_row(rd_row),
      .rd_data(rd_data), .rd_valid(rd_valid));

   swz_tile_buf #(.SWZ_B(0)) i_swz_tile_buf_id (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
      .rd_en(rd_en), .rd_raw(rd_raw), .rd_row(rd_row),
      .rd_data(rd_data_id), .rd_valid(rd_valid_id));

   function automatic int swz(input int off);
      return off ^ ((off >> 3) & (7 << 2));
   endfunction

   function automatic logic [DW-1:0] pat(input int tag, input int lin);
      return DW'((tag << 16) | lin);
   endfunction

   function automatic logic [DW-1:0] lane(input logic [T*DW-1:0] v, input int j);
      return v[j*DW +: DW];
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_col(input int col, input int tag);
      @(negedge clk);
      wr_en  = 1'b1;
      wr_col = 3'(col);
      for (int i = 0; i < T; i++) wr_data[i*DW +: DW] = pat(tag, i + 8*col);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input int idx, input bit raw);
      @(negedge clk);
      rd_en  = 1'b1;
      rd_raw = raw;
      rd_row = 3'(idx);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic fill(input int tag);
      for (int c = 0; c < T; c++) write_col(c, tag);
   endtask

   task automatic t_reset;
      chk("R1 valid", 32'(rd_valid), 32'd0);
      chk("R1 data", lane(rd_data, 0), 32'd0);
      do_read(5, 1'b0);
      for (int j = 0; j < T; j++) chk("R1 cleared", lane(rd_data, j), 32'd0);
   endtask

   task automatic t_logical(input int tag);
      fill(tag);
      for (int r = 0; r < T; r++) begin
         do_read(r, 1'b0);
         chk("R5 valid", 32'(rd_valid), 32'd1);
         for (int j = 0; j < T; j++) chk("R2/R4 readback", lane(rd_data, j), pat(tag, r + 8*j));
      end
   endtask

   task automatic t_raw(input int tag);
      for (int k = 0; k < T; k++) begin
         do_read(k, 1'b1);
         for (int j = 0; j < T; j++) begin
            dump[8*k + j] = lane(rd_data, j);
            chk("R3/R7 raw", lane(rd_data, j), pat(tag, swz(8*k + j)));
            chk("R10 identity", lane(rd_data_id, j), pat(tag, 8*k + j));
         end
      end
      for (int p = 0; p < 64; p++) where_p[int'(dump[p][5:0])] = p;
   endtask

   task automatic t_banks;
      int row0 [8] = '{0, 8, 16, 24, 4, 12, 20, 28};
      int col4 [8] = '{4, 5, 6, 7, 0, 1, 2, 3};
      chk("R8 offset 32", 32'(where_p[32]), 32'd36);
      for (int c = 0; c < T; c++) chk("R8 row0 bank", 32'(where_p[8*c] % 32), 32'(row0[c]));
      for (int r = 0; r < T; r++) chk("R8 col4 bank", 32'(where_p[r + 32] % 32), 32'(col4[r]));
      for (int a = 0; a < T; a++) begin
         logic [31:0] rmask = '0;
         logic [31:0] cmask = '0;
         for (int b = 0; b < T; b++) begin
            rmask[where_p[a + 8*b] % 32] = 1'b1;
            cmask[where_p[b + 8*a] % 32] = 1'b1;
         end
         chk("R9 row banks", 32'($countones(rmask)), 32'd8);
         chk("R9 col banks", 32'($countones(cmask)), 32'd8);
      end
   endtask

   task automatic t_collision(input int old_tag, input int new_tag);
      @(negedge clk);
      wr_en  = 1'b1;
      wr_col = 3'd2;
      for (int i = 0; i < T; i++) wr_data[i*DW +: DW] = pat(new_tag, i + 16);
      rd_en  = 1'b1;
      rd_raw = 1'b0;
      rd_row = 3'd3;
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
      chk("R6 old data", lane(rd_data, 2), pat(old_tag, 19));
      chk("R6 other lane", lane(rd_data, 5), pat(old_tag, 43));
      do_read(3, 1'b0);
      chk("R6 new data after", lane(rd_data, 2), pat(new_tag, 19));
   endtask

   task automatic t_idle;
      logic [DW-1:0] held;
      do_read(6, 1'b0);
      held = lane(rd_data, 1);
      @(negedge clk);
      chk("R5 valid drops", 32'(rd_valid), 32'd0);
      chk("R5 data held", lane(rd_data, 1), held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_logical(16'h5A);
      t_raw(16'h5A);
      t_banks();
      t_logical(16'hC3);
      t_raw(16'hC3);
      t_collision(16'hC3, 16'h77);
      t_idle();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (200000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule